// File: doc/BRIEF.md
# Serial Two-Wire Configuration Register Slave

This block lets an external two-wire (I2C) bus master read and write a bank of 8-bit configuration registers held inside a chip. The master first sends a device address byte, then, for writes, a register index byte, followed by any number of data bytes. The byte layout matches that of a small serial EEPROM. An internal register pointer advances after every data byte, whether the byte was written or read. The pointer survives the end of a transaction, so a read with no index byte continues from the place where the last access stopped. A random read is an index write, then a repeated START, then the read address.

The whole register image is available in parallel to the core. One bit acts as a run enable. Software can set it, but only a reset clears it. The slave only listens when the mode strap selects the bus. It samples SCL and SDA through synchronisers, and it pulls SDA low through an output-enable pin. It never stretches the clock.

Top module: `i2c_cfg_slave`

## Requirements
- R1: When `mode_sel` is not 2'b01 the slave ignores the bus: it never asserts `sda_oe` and no register changes.
- R2: The slave answers only the address byte 8'hBE (write) or 8'hBF (read). After any other address byte it gives no ACK, and the rest of that transaction leaves the registers unchanged.
- R3: There are 128 registers of 8 bits. All of them are 0 after reset, and `cfg_regs[8*i+7:8*i]` shows register i.
- R4: In a write transaction the byte after the device address sets the pointer from its low 7 bits. Each following data byte is stored at the pointer, and the pointer then advances.
- R5: The pointer wraps from 127 to 0, for writes and for reads.
- R6: The run bit (register 1, bit 0, also shown on `run_en`) is 0 after reset.
- R7: After a 1 has been written to the run bit, a later write of 0 leaves it at 1. The other seven bits of register 1 still take the written value.
- R8: The pointer is kept across transactions. A read that starts directly with 8'hBF returns the register at the current pointer.
- R9: A random read (write address, index byte, repeated START, read address) returns the bytes at the index and at the next indices in order.
- R10: When the master NACKs a read byte the slave releases SDA and sends no further data until the next START.
- R11: A STOP (SDA rising while SCL is high) returns the slave to idle from any state. A byte cut short by a STOP is not written.
- R12: The slave pulls SDA low during the ACK bit of every byte it accepts: the matching address byte, the index byte and each write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode strap; 2'b01 enables the slave |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_regs | output | 1024 | Flat image of all 128 registers |
| run_en | output | 1 | Sticky run bit (register 1 bit 0) |

## Verification
The bench builds the block with its defaults: 128 registers, a two-stage synchroniser and the 2'b01 strap. With 128 registers, a three-byte burst that starts at index 126 runs the pointer across the wrap within one transaction. With the short synchroniser, a bench bit time of twenty clocks still leaves room between each detected SCL edge and the next change on SDA. Register 1 sits inside the written range, so the sticky run bit can be driven by ordinary write bursts.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEV_ACK,
        ST_REGADR,
        ST_REG_ACK,
        ST_WRDATA,
        ST_WR_ACK,
        ST_RDDATA,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic                 en;
        logic [6:0]           addr;
        logic [BYTE_W-1:0]    data;
    } wr_req_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= 1'b1;
                    sda_chain <= 1'b1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_in};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_now = scl_chain[STAGES-1];
    assign sda_now = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        evt.scl_rise = scl_now & ~scl_prev;
        evt.scl_fall = ~scl_now & scl_prev;
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int         NREG     = 128,
    parameter logic [6:0] DEV_ADDR = 7'h5F,
    localparam int        AW       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    link_state_t        state;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [AW-1:0]      ptr;
    logic               is_read;
    logic               nack_seen;
    logic               oe_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        if (p == AW'(NREG - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign rd_addr = ptr;
    assign sda_oe  = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            nack_seen <= 1'b0;
            oe_q      <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_DEVADR;
                bitcnt <= '0;
                oe_q   <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADR, ST_REGADR, ST_WRDATA: begin
                        if (evt.scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_DEVADR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read <= shreg[0];
                                    oe_q    <= 1'b1;
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_REGADR) begin
                                ptr   <= shreg[AW-1:0];
                                oe_q  <= 1'b1;
                                state <= ST_REG_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr_next(ptr);
                                oe_q    <= 1'b1;
                                state   <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                shreg <= rd_data;
                                oe_q  <= ~rd_data[7];
                                state <= ST_RDDATA;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= ST_REGADR;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            oe_q  <= 1'b0;
                            state <= ST_WRDATA;
                        end
                    end
                    ST_RDDATA: begin
                        if (evt.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                bitcnt <= '0;
                                oe_q   <= 1'b0;
                                ptr    <= ptr_next(ptr);
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                oe_q   <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            nack_seen <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (!nack_seen) begin
                                shreg <= rd_data;
                                oe_q  <= ~rd_data[7];
                                state <= ST_RDDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !sda_oe); // R1

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(NREG - 1)) |-> (ptr == '0)); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (enable && evt.stop) |=> (state == ST_IDLE)); // R11

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_oe); // R10

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int NREG      = 128,
    parameter int RUN_REG   = 1,
    parameter int RUN_BIT   = 0,
    localparam int AW       = $clog2(NREG),
    localparam int FLAT_W   = NREG * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [FLAT_W-1:0] flat,
    output logic              run_en
);
    localparam logic [BYTE_W-1:0] RUN_MASK = BYTE_W'(1) << RUN_BIT;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [BYTE_W-1:0] q;
        logic              hit;
        assign hit = req.en && (req.addr[AW-1:0] == AW'(i));
        if (i == RUN_REG) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (hit)
                    q <= req.data | (q & RUN_MASK);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (hit)
                    q <= req.data;
            end
        end
        assign flat[i*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = flat[int'(rd_addr)*BYTE_W +: BYTE_W];
    end

    assign run_en = flat[RUN_REG*BYTE_W + RUN_BIT];

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        run_en |=> run_en); // R7

    AST_RUN_RESET: assert property (@(posedge clk)
        rst |=> !run_en); // R6

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         NREG        = 128,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] MODE_ON     = 2'b01,
    parameter logic [6:0] DEV_ADDR    = 7'h5F,
    localparam int        AW          = $clog2(NREG),
    localparam int        FLAT_W      = NREG * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [FLAT_W-1:0] cfg_regs,
    output logic              run_en
);
    bus_evt_t          evt;
    wr_req_t           req;
    logic              enable;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data;

    assign enable = (mode_sel == MODE_ON);

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_link_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    always_comb begin
        req      = '0;
        req.en   = wr_en;
        req.addr = 7'(wr_addr);
        req.data = wr_data;
    end

    i2c_reg_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flat    (cfg_regs),
        .run_en  (run_en)
    );

endmodule

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
    localparam int NREG = 128;
    localparam int Q    = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode_sel = 2'b01;
    logic              scl = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_line;
    logic              sda_oe;
    logic [NREG*8-1:0] cfg_regs;
    logic              run_en;

    int n_run  = 0;
    int n_fail = 0;
    int model [NREG];
    int mptr = 0;
    int oe_while_off = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_cfg_slave u_i2c_cfg_slave (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs),
        .run_en   (run_en)
    );

    always @(negedge clk) if (!rst && mode_sel != 2'b01 && sda_oe) oe_while_off++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); acked = ~sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); d[i] = sda_line; wq(); scl = 1'b0; wq();
        end
        sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
    endtask

    function automatic void model_write(input int v);
        if (mptr == 1) model[1] = v | (model[1] & 1);
        else model[mptr] = v;
        mptr = (mptr + 1) % NREG;
    endfunction

    task automatic compare_all(input string req);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(cfg_regs[i*8 +: 8]) != model[i]) begin
                if (bad == 0) begin first_act = int'(cfg_regs[i*8 +: 8]); first_exp = model[i]; end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic write_burst(input int idx, input int vals[$], input string req);
        bit a;
        int nack = 0;
        bus_start();
        send_byte(8'hBE, a); if (!a) nack++;
        send_byte(8'(idx), a); if (!a) nack++;
        mptr = idx % NREG;
        foreach (vals[k]) begin
            send_byte(8'(vals[k]), a); if (!a) nack++;
            model_write(vals[k]);
        end
        bus_stop();
        chk(nack == 0, req, nack, 0);
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) model[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wq();

        // R3 R6: reset state
        compare_all("R3 reset image");
        chk(run_en == 1'b0 && sda_oe == 1'b0, "R6 run_en after reset", int'(run_en), 0);

        // R4 R12: burst write with ACKs
        write_burst(10, '{8'h3C, 8'h81, 8'hE7}, "R12 ack on accepted bytes");
        compare_all("R4 burst write");

        // R9 R10: random read of two bytes, NACK on the second
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'd10, a);
        mptr = 10;
        bus_start();
        send_byte(8'hBF, a);
        chk(a, "R9 read address ack", int'(a), 1);
        recv_byte(1'b1, d);
        chk(int'(d) == model[10], "R9 random read first", int'(d), model[10]);
        mptr = 11;
        recv_byte(1'b0, d);
        chk(int'(d) == model[11], "R9 random read second", int'(d), model[11]);
        mptr = 12;
        wq(); wq();
        chk(sda_oe == 1'b0, "R10 released after nack", int'(sda_oe), 0);
        bus_stop();

        // R8: current-address read continues at the kept pointer
        bus_start();
        send_byte(8'hBF, a);
        recv_byte(1'b0, d);
        chk(int'(d) == model[12], "R8 current address read", int'(d), model[12]);
        mptr = 13;
        bus_stop();

        // R5: wrap on write then on read
        write_burst(126, '{8'h11, 8'h22, 8'h33}, "R5 wrap write acks");
        compare_all("R5 wrap write image");
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'd127, a);
        bus_start();
        send_byte(8'hBF, a);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d);
        chk(int'(d) == model[0], "R5 wrap read", int'(d), model[0]);
        mptr = 1;
        bus_stop();

        // R6 R7: sticky run bit
        write_burst(1, '{8'h01}, "R7 set run acks");
        chk(run_en == 1'b1, "R6 run set by write", int'(run_en), 1);
        write_burst(1, '{8'hA4}, "R7 clear attempt acks");
        chk(run_en == 1'b1, "R7 run bit sticky", int'(run_en), 1);
        chk(int'(cfg_regs[15:8]) == 8'hA5, "R7 other bits writable", int'(cfg_regs[15:8]), 8'hA5);

        // R2: foreign address ignored
        bus_start();
        send_byte(8'hA0, a);
        chk(!a, "R2 foreign address nack", int'(a), 0);
        send_byte(8'h05, a);
        send_byte(8'h77, a);
        bus_stop();
        compare_all("R2 foreign transaction no effect");

        // R11: STOP in the middle of a data byte
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'd20, a);
        mptr = 20;
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        bus_stop();
        compare_all("R11 partial byte dropped");
        write_burst(20, '{8'h5A}, "R11 bus usable after stop");
        compare_all("R11 write after stop");

        // R1: strap off
        mode_sel = 2'b00;
        wq();
        bus_start();
        send_byte(8'hBE, a);
        chk(!a, "R1 no ack when disabled", int'(a), 0);
        send_byte(8'd30, a);
        send_byte(8'h99, a);
        bus_stop();
        compare_all("R1 registers unchanged when disabled");
        chk(oe_while_off == 0, "R1 sda_oe never driven", oe_while_off, 0);
        mode_sel = 2'b01;
        wq();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(negedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule